// File: doc/BRIEF.md
# SMI Request Status and Enable Register Block

This block collects system-management interrupt requests from the power-management sources of a chipset and holds them in two status registers, called primary and secondary here. Each source pulse latches a sticky status bit. Two matching enable registers choose which latched requests may drive the active-low interrupt output `smi_n` to the processor. The primary enable register also carries a global enable in its top bit.

Software reads and writes the four registers through a small index window that starts at `IDX_BASE`, which defaults to 0x90.

- Status bits clear when software writes a 1 to them.
- The top bit of the primary status register is not a stored bit. It is a summary that reads as 1 whenever any secondary status bit is set.
- Software can clear the global enable and then set it again to force a fresh high-then-low edge on `smi_n` while requests remain pending.

The register access is a plain single-cycle port with no valid/ready handshake:
- A write takes effect on the clock edge where `reg_wr` is high.
- Reads are combinational from `reg_idx`.
- The port never stalls, so there is no back-pressure.

Top module: `smi_regs`

## Requirements
- R1: After reset, all four registers read 0x00 and `smi_n` is 1.
- R2: A 1 on `src_pulse` bits 0 to 6 sets primary status bits 0 to 6, and a 1 on `src_pulse` bit 7 (software request) sets secondary status bit 1. Each takes effect at the next clock edge, and any number of bits may set in the same cycle.
- R3: A 1 on either `ext_pin` bit sets secondary status bit 0 at the next clock edge.
- R4: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If a source sets a status bit in the same cycle that a write-one-to-clear targets it, the bit ends up set.
- R6: Primary status bit 7 reads 1 exactly when the secondary status register is nonzero, and writes to it have no effect.
- R7: The enable registers read back what was written. The exceptions are secondary enable bits 7 to 2 and secondary status bits 7 to 2, which always read 0. Primary enable bit 7 is the global enable.
- R8: One clock after the registers hold a 1 in the global enable and a status bit whose enable bit is also 1, `smi_n` is 0. Otherwise it is 1 one clock later.
- R9: With a request pending, writing the global enable to 0 and then to 1 drives `smi_n` high and then low again, each change one cycle after its write.
- R10: The window holds four registers, in this order: primary status at `IDX_BASE`+0, secondary status at +1, primary enable at +2, secondary enable at +3. Any other index reads 0x00 and ignores writes.
- R11: When primary status reads 0x00 and one clock has passed since it last changed, `smi_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | REG_W | Per-source request pulses: 0 timer A, 1 timer B, 2 wake A, 3 wake B, 4 I/O restart, 5 halt cycle, 6 CPU restart, 7 software |
| ext_pin | input | 2 | External request pins (active high, already synchronized) |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_idx` (combinational) |
| smi_n | output | 1 | Active-low interrupt request, registered |

## Verification
Two kinds of result have different latencies, and the bench counts each register on the path before it samples:
- A source pulse or a register write changes what the status and enable registers read back at the first clock edge. The bench therefore drives on a falling edge and reads in the same low phase that follows the next rising edge.
- `smi_n` sits one register further back, so every interrupt check waits one extra full cycle after the status or enable change it depends on.

The toggle test also samples `smi_n` in the cycle directly after the enable write, to confirm it has not yet moved.

// File: rtl/smi_regs_pkg.sv
package smi_regs_pkg;
  // Register selector within the index window; order is part of the map.
  typedef enum logic [1:0] {
    SEL_STAT_PRI = 2'd0,
    SEL_STAT_SEC = 2'd1,
    SEL_EN_PRI   = 2'd2,
    SEL_EN_SEC   = 2'd3
  } reg_sel_e;

  localparam int WINDOW_REGS = 4;
  localparam int SEC_USED    = 2;  // external + software
endpackage

// File: rtl/smi_src_merge.sv
module smi_src_merge #(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0] src_pulse,
  input  logic [1:0]       ext_pin,
  output logic [REG_W-2:0] set_pri,
  output logic [REG_W-1:0] set_sec
);
  localparam int PRI_W = REG_W - 1;

  // Primary sources map one to one.
  for (genvar i = 0; i < PRI_W; i++) begin : g_pri
    assign set_pri[i] = src_pulse[i];
  end

  // Secondary: bit 0 external (either pin), bit 1 software, rest unused.
  for (genvar j = 0; j < REG_W; j++) begin : g_sec
    if (j == 0) begin : g_ext
      assign set_sec[j] = |ext_pin;
    end else if (j == 1) begin : g_sw
      assign set_sec[j] = src_pulse[REG_W-1];
    end else begin : g_zero
      assign set_sec[j] = 1'b0;
    end
  end
endmodule

// File: rtl/smi_w1c_reg.sv
module smi_w1c_reg #(
  parameter int         W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr;
  logic [W-1:0] q_next;

  always_comb begin
    clr    = wr_i ? wdata_i : '0;
    // set applied after clear so a simultaneous set survives
    q_next = ((q_o & ~clr) | set_i) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & MASK) != '0) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));

  a_r4_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((q_o & $past(wdata_i & ~set_i)) == '0));

  a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i & MASK;
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == ($past(wdata_i) & MASK)));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/smi_irq_out.sv
module smi_irq_out #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-2:0] stat_pri,
  input  logic [REG_W-2:0] en_pri,
  input  logic [REG_W-1:0] stat_sec,
  input  logic [REG_W-1:0] en_sec,
  input  logic             glob_en,
  output logic             smi_n_o
);
  logic pending;

  always_comb pending = (|(stat_pri & en_pri)) | (|(stat_sec & en_sec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_n_o <= 1'b1;
    else        smi_n_o <= ~(glob_en & pending);
  end

  a_r9_gen_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> smi_n_o);

  a_r8_nothing_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pri == '0 && stat_sec == '0) |=> smi_n_o);
endmodule

// File: rtl/smi_regs.sv
module smi_regs
  import smi_regs_pkg::*;
#(
  parameter int         REG_W    = 8,
  parameter logic [7:0] IDX_BASE = 8'h90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_pulse,
  input  logic [1:0]       ext_pin,
  input  logic             reg_wr,
  input  logic [7:0]       reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             smi_n
);
  localparam int               PRI_W    = REG_W - 1;
  localparam logic [REG_W-1:0] SEC_MASK = REG_W'((1 << SEC_USED) - 1);

  logic [PRI_W-1:0] set_pri;
  logic [REG_W-1:0] set_sec;
  logic [PRI_W-1:0] stat_pri_q;
  logic [REG_W-1:0] stat_sec_q;
  logic [REG_W-1:0] en_pri_q;
  logic [REG_W-1:0] en_sec_q;

  logic [7:0] offs;
  logic       hit;
  reg_sel_e   sel;
  logic       wr_sp, wr_ss, wr_ep, wr_es;

  // Index decode
  always_comb begin
    offs  = reg_idx - IDX_BASE;
    hit   = (offs < 8'(WINDOW_REGS));
    sel   = reg_sel_e'(offs[1:0]);
    wr_sp = reg_wr && hit && (sel == SEL_STAT_PRI);
    wr_ss = reg_wr && hit && (sel == SEL_STAT_SEC);
    wr_ep = reg_wr && hit && (sel == SEL_EN_PRI);
    wr_es = reg_wr && hit && (sel == SEL_EN_SEC);
  end

  smi_src_merge #(.REG_W(REG_W)) u_merge (
    .src_pulse (src_pulse),
    .ext_pin   (ext_pin),
    .set_pri   (set_pri),
    .set_sec   (set_sec)
  );

  smi_w1c_reg #(.W(PRI_W), .MASK('1)) u_stat_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_pri),
    .wr_i    (wr_sp),
    .wdata_i (reg_wdata[PRI_W-1:0]),
    .q_o     (stat_pri_q)
  );

  smi_w1c_reg #(.W(REG_W), .MASK(SEC_MASK)) u_stat_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_sec),
    .wr_i    (wr_ss),
    .wdata_i (reg_wdata),
    .q_o     (stat_sec_q)
  );

  smi_en_reg #(.W(REG_W), .MASK('1)) u_en_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_ep),
    .wdata_i (reg_wdata),
    .q_o     (en_pri_q)
  );

  smi_en_reg #(.W(REG_W), .MASK(SEC_MASK)) u_en_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_es),
    .wdata_i (reg_wdata),
    .q_o     (en_sec_q)
  );

  smi_irq_out #(.REG_W(REG_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_pri (stat_pri_q),
    .en_pri   (en_pri_q[PRI_W-1:0]),
    .stat_sec (stat_sec_q),
    .en_sec   (en_sec_q),
    .glob_en  (en_pri_q[REG_W-1]),
    .smi_n_o  (smi_n)
  );

  // Read mux; the primary status top bit is the secondary summary.
  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_STAT_PRI: reg_rdata = {(|stat_sec_q), stat_pri_q};
        SEL_STAT_SEC: reg_rdata = stat_sec_q;
        SEL_EN_PRI:   reg_rdata = en_pri_q;
        SEL_EN_SEC:   reg_rdata = en_sec_q;
        default:      reg_rdata = '0;
      endcase
    end
  end

  a_r10_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit) |=> ($stable(en_pri_q) && $stable(en_sec_q)));

  a_r8_enabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pri_q[REG_W-1] && ((stat_pri_q & en_pri_q[PRI_W-1:0]) != '0)) |=> !smi_n);

  a_r11_low_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !smi_n |-> ($past(stat_pri_q) != '0 || $past(stat_sec_q) != '0));
endmodule

// File: tb/smi_regs_test.sv
module smi_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_pulse = '0;
  logic [1:0] ext_pin = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       smi_n;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  smi_regs #(.REG_W(8), .IDX_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ext_pin(ext_pin),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smi_n(smi_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] data);
    reg_idx = idx;
    reg_wdata = data;
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [1:0] e);
    src_pulse = s;
    ext_pin = e;
    tick();
    src_pulse = '0;
    ext_pin = '0;
  endtask

  task automatic clear_all;
    wr(BASE + 8'd0, 8'hFF);
    wr(BASE + 8'd1, 8'hFF);
    wr(BASE + 8'd2, 8'h00);
    wr(BASE + 8'd3, 8'h00);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 8'(i), d);
      chk("R1 reset reg", d, 0);
    end
    chk("R1 reset smi_n", smi_n, 1);

    // R10 unmapped indices read zero, writes ignored
    wr(8'h94, 8'hFF);
    wr(8'h8F, 8'hFF);
    rd(8'h94, d); chk("R10 miss read", d, 0);
    rd(8'h8F, d); chk("R10 miss read", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 8'(i), d);
      chk("R10 window untouched", d, 0);
    end

    // R7 enable readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(BASE + 8'd2, 8'(v));
      rd(BASE + 8'd2, d); chk("R7 en pri", d, v);
      wr(BASE + 8'd3, 8'(v));
      rd(BASE + 8'd3, d); chk("R7 en sec", d, v & 3);
    end
    tick();
    chk("R8 no status high", smi_n, 1);

    // R2 R3 R8 R4 per-source sweep
    for (int s = 0; s < 10; s++) begin
      for (int e = 0; e < 2; e++) begin
        for (int g = 0; g < 2; g++) begin
          logic [7:0] sp, xp, exp_a, exp_b, epri, esec;
          bit is_pri;
          is_pri = (s < 7);
          sp = (s < 8) ? 8'(1 << s) : 8'h00;
          xp = (s == 8) ? 8'h01 : ((s == 9) ? 8'h02 : 8'h00);
          exp_a = is_pri ? 8'(1 << s) : 8'h00;
          exp_b = (s == 7) ? 8'h02 : ((s >= 8) ? 8'h01 : 8'h00);
          if (!is_pri) exp_a = 8'h80;
          epri = 8'(g << 7) | ((is_pri && e == 1) ? exp_a : 8'h00);
          esec = (!is_pri && e == 1) ? exp_b : 8'h00;
          clear_all();
          wr(BASE + 8'd2, epri);
          wr(BASE + 8'd3, esec);
          tick();
          chk("R8 idle high", smi_n, 1);
          pulse(sp, xp[1:0]);
          rd(BASE + 8'd0, d); chk(is_pri ? "R2 pri set" : "R6 summary", d, exp_a);
          rd(BASE + 8'd1, d); chk((s >= 8) ? "R3 ext set" : "R2 sec set", d, exp_b);
          tick();
          chk("R8 smi_n level", smi_n, !(g == 1 && e == 1));
          wr(BASE + (is_pri ? 8'd0 : 8'd1), 8'hFF);
          rd(BASE + 8'd0, d); chk("R4 cleared", d, 0);
          tick();
          chk("R11 zero status high", smi_n, 1);
        end
      end
    end

    // R2 all sources at once
    clear_all();
    pulse(8'hFF, 2'b11);
    rd(BASE + 8'd0, d); chk("R2 all pri", d, 8'hFF);
    rd(BASE + 8'd1, d); chk("R2 all sec", d, 8'h03);

    // R4 W1C sweep on primary
    clear_all();
    for (int m = 0; m < 256; m++) begin
      pulse(8'h7F, 2'b00);
      wr(BASE + 8'd0, 8'(m));
      rd(BASE + 8'd0, d); chk("R4 pri w1c", d, 8'h7F & ~m);
    end
    // R4 W1C sweep on secondary
    wr(BASE + 8'd0, 8'hFF);
    for (int m = 0; m < 256; m++) begin
      pulse(8'h80, 2'b01);
      wr(BASE + 8'd1, 8'(m));
      rd(BASE + 8'd1, d); chk("R4 sec w1c", d, 3 & ~m);
      rd(BASE + 8'd0, d); chk("R6 summary", d, ((3 & ~m) != 0) ? 8'h80 : 8'h00);
    end

    // R6 summary bit ignores writes
    clear_all();
    pulse(8'h80, 2'b00);
    wr(BASE + 8'd0, 8'h80);
    rd(BASE + 8'd0, d); chk("R6 summary write ignored", d, 8'h80);
    wr(BASE + 8'd1, 8'hFF);
    rd(BASE + 8'd0, d); chk("R6 summary drops", d, 8'h00);

    // R5 set beats clear
    clear_all();
    pulse(8'h04, 2'b00);
    src_pulse = 8'h04;
    wr(BASE + 8'd0, 8'hFF);
    src_pulse = 8'h00;
    rd(BASE + 8'd0, d); chk("R5 pri set wins", d, 8'h04);
    pulse(8'h00, 2'b10);
    ext_pin = 2'b01;
    wr(BASE + 8'd1, 8'hFF);
    ext_pin = 2'b00;
    rd(BASE + 8'd1, d); chk("R5 sec set wins", d, 8'h01);

    // R9 global enable toggle
    clear_all();
    wr(BASE + 8'd2, 8'hFF);
    wr(BASE + 8'd3, 8'h03);
    pulse(8'h01, 2'b00);
    tick();
    chk("R9 pending low", smi_n, 0);
    wr(BASE + 8'd2, 8'h7F);
    chk("R9 latency still low", smi_n, 0);
    tick();
    chk("R9 gen off high", smi_n, 1);
    wr(BASE + 8'd2, 8'hFF);
    chk("R9 latency still high", smi_n, 1);
    tick();
    chk("R9 gen on low again", smi_n, 0);

    // R11 cleared status gives high output
    wr(BASE + 8'd0, 8'hFF);
    tick();
    rd(BASE + 8'd0, d); chk("R11 status zero", d, 0);
    chk("R11 smi_n high", smi_n, 1);

    summary();
  end
endmodule